// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins controlled through a plain register bus with a one-cycle read/write strobe. Software sets which pins drive and which receive, and it sets the value driven on the output pins. The block exposes an output-enable vector and an output-value vector to the pad ring. Pad inputs pass through a two-flop synchroniser before any other logic sees them.

Every pin also acts as an interrupt source. Its 2-bit trigger type selects one of four conditions: low level, high level, rising edge or falling edge. A pin whose condition is met sets its bit in a status register, whether or not that pin is masked. Software clears a status bit by writing a 1 to it. A level source that is still active sets its bit again at once. An edge event stays latched until software clears it.

A single registered interrupt line is high whenever some status bit is set while its mask bit is also set. The trigger fields are packed two bits per pin into two configuration words. The lower word holds the lower half of the pins and the upper word holds the upper half.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held, pad_oe, pad_out, irq, the mask register and the status register are all zero.
- R2: Offset 0x04 holds the direction register, where bit 1 means output. pad_oe equals its value from the clock edge that follows a write.
- R3: Offset 0x00 holds the output data, and pad_out equals it from the edge after a write. A read of 0x00 returns the data bit for each output pin and the synchronised pad bit for each input pin.
- R4: A read of offset 0x08 returns the synchronised pad inputs. A change on pad_in becomes visible there after two rising edges.
- R5: Offset 0x0C holds the trigger fields of pins 0 to 15, and offset 0x10 holds those of pins 16 to 31. The field of pin p occupies bits 2*(p mod 16)+1:2*(p mod 16). The field values are 00 for low level, 01 for high level, 10 for rising edge and 11 for falling edge.
- R6: A level-triggered pin sets its status bit on every edge on which its synchronised value matches the level. Clearing the bit while the level still holds leaves it reading 1.
- R7: The status register sits at offset 0x18. An edge event on the synchronised value sets the status bit one edge after the synchronised value changes. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and an edge bit stays set until it is cleared.
- R8: The mask register sits at offset 0x14. Status bits are set regardless of the mask. irq is the OR of status AND mask, registered one edge later.
- R9: Reads of any offset other than the seven listed above, including offsets that are not word-aligned, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Asynchronous pad input values |
| pad_oe | output | 32 | Output enable per pin |
| pad_out | output | 32 | Value driven on output pins |
| irq | output | 1 | Combined registered interrupt |

## Verification
Two situations are hardest to reach from the ports. The first is a write that clears a status bit on the same edge at which its level source is still active. The second is a falling edge on a pin whose trigger field sits in the upper configuration word at a nonzero field position. A directed sequence reaches both by holding a pad high across the clearing write and by toggling a pin above 16 whose type is falling-edge. Random pad toggles mixed with random configuration, mask and clear writes then check every register and output each cycle against a bench model of the synchroniser, trigger and status behaviour.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    typedef enum logic [1:0] {
        TRG_LVL_LO = 2'b00,
        TRG_LVL_HI = 2'b01,
        TRG_RISE   = 2'b10,
        TRG_FALL   = 2'b11
    } trig_e;

    localparam int OFS_DATA  = 'h00;
    localparam int OFS_DIR   = 'h04;
    localparam int OFS_PAD   = 'h08;
    localparam int OFS_CFGLO = 'h0C;
    localparam int OFS_CFGHI = 'h10;
    localparam int OFS_MASK  = 'h14;
    localparam int OFS_STAT  = 'h18;

endpackage

// File: rtl/gpb_sync.sv
// Multi-stage synchroniser; also provides the stage after the output for edge compare.
module gpb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_prev
);
    localparam int LAST = STAGES;

    logic [LAST:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s <= LAST; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q      = chain[LAST-1];
    assign q_prev = chain[LAST];
endmodule

// File: rtl/gpb_trigger.sv
// Per-pin trigger decode: level or edge condition from the packed config words.
module gpb_trigger
    import gpb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] cfg_lo,
    input  logic [NPINS-1:0] cfg_hi,
    input  logic [NPINS-1:0] cur,
    input  logic [NPINS-1:0] prev,
    output logic [NPINS-1:0] hit
);
    localparam int HALF = NPINS / 2;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int SH = 2 * (p % HALF);
        trig_e kind;
        logic  fire;

        if (p < HALF) begin : g_low_word
            assign kind = trig_e'(cfg_lo[SH +: 2]);
        end else begin : g_high_word
            assign kind = trig_e'(cfg_hi[SH +: 2]);
        end

        always_comb begin
            unique case (kind)
                TRG_LVL_LO: fire = ~cur[p];
                TRG_LVL_HI: fire = cur[p];
                TRG_RISE:   fire = cur[p] & ~prev[p];
                TRG_FALL:   fire = ~cur[p] & prev[p];
                default:    fire = 1'b0;
            endcase
        end

        assign hit[p] = fire;
    end
endmodule

// File: rtl/gpb_regs.sv
// Register file, write-one-to-clear status, registered interrupt and read mux.
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_sync,
    input  logic [NPINS-1:0]  trig_hit,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  dout_o,
    output logic [NPINS-1:0]  cfg_lo_o,
    output logic [NPINS-1:0]  cfg_hi_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_PAD   = ADDR_W'(OFS_PAD);
    localparam logic [ADDR_W-1:0] A_CFGLO = ADDR_W'(OFS_CFGLO);
    localparam logic [ADDR_W-1:0] A_CFGHI = ADDR_W'(OFS_CFGHI);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    logic [NPINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q;
    logic [NPINS-1:0] clr_bits;
    logic             irq_q;
    logic             wr_en, rd_en;

    assign wr_en = bus_sel & bus_we;
    assign rd_en = bus_sel & ~bus_we;

    always_comb begin
        clr_bits = '0;
        if (wr_en && bus_addr == A_STAT) begin
            clr_bits = bus_wdata;
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            stat_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            // a still-active source wins over a clear on the same edge
            stat_q <= (stat_q & ~clr_bits) | trig_hit;
            irq_q  <= |(stat_q & mask_q);
            if (wr_en) begin
                case (bus_addr)
                    A_DATA:  data_q   <= bus_wdata;
                    A_DIR:   dir_q    <= bus_wdata;
                    A_CFGLO: cfg_lo_q <= bus_wdata;
                    A_CFGHI: cfg_hi_q <= bus_wdata;
                    A_MASK:  mask_q   <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Output process: read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                A_DATA:  bus_rdata = (dir_q & data_q) | (~dir_q & pad_sync);
                A_DIR:   bus_rdata = dir_q;
                A_PAD:   bus_rdata = pad_sync;
                A_CFGLO: bus_rdata = cfg_lo_q;
                A_CFGHI: bus_rdata = cfg_hi_q;
                A_MASK:  bus_rdata = mask_q;
                A_STAT:  bus_rdata = stat_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign dir_o    = dir_q;
    assign dout_o   = data_q;
    assign cfg_lo_o = cfg_lo_q;
    assign cfg_hi_o = cfg_hi_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic              irq
);
    logic [NPINS-1:0] pad_sync, pad_prev, hit;
    logic [NPINS-1:0] cfg_lo, cfg_hi;

    gpb_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pad_in),
        .q      (pad_sync),
        .q_prev (pad_prev)
    );

    gpb_trigger #(.NPINS(NPINS)) u_trig (
        .cfg_lo (cfg_lo),
        .cfg_hi (cfg_hi),
        .cur    (pad_sync),
        .prev   (pad_prev),
        .hit    (hit)
    );

    gpb_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_sync  (pad_sync),
        .trig_hit  (hit),
        .dir_o     (pad_oe),
        .dout_o    (pad_out),
        .cfg_lo_o  (cfg_lo),
        .cfg_hi_o  (cfg_hi),
        .irq_o     (irq)
    );
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
    import gpb_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic              irq
);
    logic mapped;
    assign mapped = (bus_addr == ADDR_W'(OFS_DATA))  || (bus_addr == ADDR_W'(OFS_DIR))   ||
                    (bus_addr == ADDR_W'(OFS_PAD))   || (bus_addr == ADDR_W'(OFS_CFGLO)) ||
                    (bus_addr == ADDR_W'(OFS_CFGHI)) || (bus_addr == ADDR_W'(OFS_MASK))  ||
                    (bus_addr == ADDR_W'(OFS_STAT));

    a_r2_oe_tracks_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=> (pad_oe == $past(bus_wdata)));

    a_r3_out_tracks_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(OFS_DATA)) |=> (pad_out == $past(bus_wdata)));

    a_r8_mask_off_silences_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(OFS_MASK) && bus_wdata == '0) |-> ##2 !irq);

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !mapped) |-> (bus_rdata == '0));
endmodule

bind gpio_irq_bank gpb_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N  = 32;
    localparam int AW = 5;
    localparam logic [AW-1:0] R_DATA = 5'h00, R_DIR = 5'h04, R_PAD = 5'h08,
                              R_CLO = 5'h0C, R_CHI = 5'h10, R_MASK = 5'h14, R_STAT = 5'h18;

    logic          clk = 1'b0, rst_n = 1'b0, sel = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  wdata = '0, pad_in = '0;
    logic [N-1:0]  rdata, pad_oe, pad_out;
    logic          irq;

    int n_cmp = 0, n_bad = 0;

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    always #2 clk = ~clk;

    // Bench model state
    logic [N-1:0] m_s1, m_s2, m_prev, m_data, m_dir, m_lo, m_hi, m_mask, m_stat;
    logic         m_irq;

    function automatic logic [N-1:0] exp_hits(input logic [N-1:0] lo, hi, cur, prv);
        logic [N-1:0] h;
        h = '0;
        for (int p = 0; p < N; p++) begin
            logic [1:0] t;
            t = (p < N/2) ? lo[2*p +: 2] : hi[2*(p-N/2) +: 2];
            case (t)
                2'b00:   h[p] = ~cur[p];
                2'b01:   h[p] = cur[p];
                2'b10:   h[p] = cur[p] & ~prv[p];
                default: h[p] = ~cur[p] & prv[p];
            endcase
        end
        return h;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_data = '0; m_dir = '0;
            m_lo = '0; m_hi = '0; m_mask = '0; m_stat = '0; m_irq = 1'b0;
        end else begin
            logic [N-1:0] hits, clr;
            logic         nirq;
            hits   = exp_hits(m_lo, m_hi, m_s2, m_prev);
            nirq   = |(m_stat & m_mask);
            clr    = (sel && we && addr == R_STAT) ? wdata : '0;
            m_stat = (m_stat & ~clr) | hits;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
            if (sel && we) begin
                case (addr)
                    R_DATA: m_data = wdata;
                    R_DIR:  m_dir  = wdata;
                    R_CLO:  m_lo   = wdata;
                    R_CHI:  m_hi   = wdata;
                    R_MASK: m_mask = wdata;
                    default: ;
                endcase
            end
            m_irq = nirq;
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [AW-1:0] a, input string tag, input logic [N-1:0] exp);
        sel = 1'b1; we = 1'b0; addr = a;
        #0.2;
        chk(tag, rdata, exp);
    endtask

    task automatic observe();
        chk("R2 pad_oe", pad_oe, m_dir);
        chk("R3 pad_out", pad_out, m_data);
        chk("R8 irq", {31'd0, irq}, {31'd0, m_irq});
        peek(R_DATA, "R3 data read", (m_dir & m_data) | (~m_dir & m_s2));
        peek(R_PAD,  "R4 pad read", m_s2);
        peek(R_CLO,  "R5 cfg low", m_lo);
        peek(R_CHI,  "R5 cfg high", m_hi);
        peek(R_MASK, "R8 mask", m_mask);
        peek(R_STAT, "R6 R7 status", m_stat);
    endtask

    task automatic cycle(input logic s, input logic w, input logic [AW-1:0] a,
                         input logic [N-1:0] d, input logic [N-1:0] pads);
        @(negedge clk);
        observe();
        sel = s; we = w; addr = a; wdata = d; pad_in = pads;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, R_DATA, '0, pad_in);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        cycle(1'b1, 1'b1, a, d, pad_in);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd915);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 irq", {31'd0, irq}, '0);
        peek(R_STAT, "R1 status", '0);
        peek(R_MASK, "R1 mask", '0);
        sel = 1'b0;
        rst_n = 1'b1;

        // All pins rising edge, pin 5 high level, pin 20 falling edge
        wr(R_CLO, 32'hAAAA_A6AA);
        wr(R_CHI, 32'hAAAA_ABAA);
        wr(R_STAT, '1);
        idle(4);
        peek(R_STAT, "R7 cleared", '0); sel = 1'b0;

        cycle(1'b0, 1'b0, R_DATA, '0, 32'h0010_0008);
        idle(4);
        peek(R_STAT, "R7 rising latched, R5 falling pin ignores rise", 32'h0000_0008); sel = 1'b0;
        wr(R_STAT, '0);
        idle(2);
        peek(R_STAT, "R7 zero write keeps bit", 32'h0000_0008); sel = 1'b0;
        cycle(1'b0, 1'b0, R_DATA, '0, '0);
        idle(4);
        peek(R_STAT, "R5 upper-word falling edge", 32'h0010_0008); sel = 1'b0;
        wr(R_STAT, '1);
        idle(2);
        peek(R_STAT, "R7 write one clears", '0); sel = 1'b0;

        // Level high on pin 5, clear while active
        cycle(1'b0, 1'b0, R_DATA, '0, 32'h0000_0020);
        idle(4);
        peek(R_STAT, "R6 level sets", 32'h0000_0020); sel = 1'b0;
        wr(R_STAT, 32'h0000_0020);
        idle(1);
        peek(R_STAT, "R6 level re-sets after clear", 32'h0000_0020); sel = 1'b0;
        wr(R_MASK, 32'h0000_0020);
        idle(3);
        chk("R8 irq raised", {31'd0, irq}, 32'd1);
        cycle(1'b0, 1'b0, R_DATA, '0, '0);
        idle(3);
        wr(R_STAT, '1);
        idle(3);
        chk("R8 irq drops after clear", {31'd0, irq}, '0);
        cycle(1'b0, 1'b0, R_DATA, '0, 32'h0000_0008);
        idle(5);
        peek(R_STAT, "R8 status set while masked off", 32'h0000_0008); sel = 1'b0;
        chk("R8 irq stays low when unmasked bit absent", {31'd0, irq}, '0);

        // R9 unmapped offsets
        @(negedge clk);
        peek(5'h1C, "R9 unmapped", '0);
        peek(5'h02, "R9 misaligned", '0);
        sel = 1'b0;

        // R2/R3/R4 directed
        wr(R_DIR, 32'h0000_FFFF);
        wr(R_DATA, 32'h1234_5678);
        cycle(1'b0, 1'b0, R_DATA, '0, 32'hABCD_0000);
        @(negedge clk);
        peek(R_PAD, "R4 one edge still old", 32'h0000_0008);
        sel = 1'b0;
        @(negedge clk);
        peek(R_PAD, "R4 two edges new", 32'hABCD_0000);
        peek(R_DATA, "R3 mixed data read", 32'hABCD_5678);
        chk("R2 pad_oe value", pad_oe, 32'h0000_FFFF);
        sel = 1'b0;

        // Constrained random phase
        for (int k = 0; k < 3000; k++) begin
            int unsigned op;
            logic [N-1:0] pads;
            op   = $urandom_range(0, 9);
            pads = pad_in;
            if (op < 3) pads = pad_in ^ ($urandom & $urandom & $urandom);
            case (op)
                3: cycle(1'b1, 1'b1, R_DIR,  $urandom, pads);
                4: cycle(1'b1, 1'b1, R_DATA, $urandom, pads);
                5: cycle(1'b1, 1'b1, R_CLO,  $urandom, pads);
                6: cycle(1'b1, 1'b1, R_CHI,  $urandom, pads);
                7: cycle(1'b1, 1'b1, R_MASK, ($urandom_range(0, 3) == 0) ? '0 : $urandom, pads);
                8: cycle(1'b1, 1'b1, R_STAT, $urandom, pads);
                default: cycle(1'b0, 1'b0, R_DATA, '0, pads);
            endcase
        end
        idle(4);
        report();
    end
endmodule